// File: doc/BRIEF.md
# Video Line Timing and Blanking Generator

This block sits behind the sync input pins of a video encoder and turns an incoming horizontal and vertical sync pair into the timing that the rest of the encoder runs on. It counts pixel clocks from the leading edge of each horizontal sync and lines from one horizontal sync to the next. From these counts it produces an active-video window, a composite blanking signal and a line number. It also derives odd/even field parity and raises a flag that tells the subcarrier logic to free-run whenever the measured line length does not fit the selected standard.

A 3-bit mode code picks one of seven line standards. Each standard fixes the clocks per line, the porch before active video and the number of active pixels. A signed trim moves the horizontal blanking edges by up to 15 clocks either way. A 2-bit select lengthens the top blanking of each field. Polarity inputs let the sync and field pins be active high or active low. Field parity can come from sync coincidence or straight from the field pin.

All outputs are plain control signals with no handshake. A mode change is applied under reset.

Top module: `vtg_line_timing`

## Requirements
- R1: Mode codes and expected clocks per line: 000 = 910, 001 = 780, 010 = 858, 100 = 1135, 101 = 944, 110 = 864, 111 = 780. Each H leading edge after the first one since reset ends a measurement. Two edges after the sampling edge of that H leading edge, `free_run_o` is 1 if the measured count differs from the expected count, and 0 if it matches.
- R2: Take the edge that first samples the H leading edge as edge 0. Pixel index k is current after edge k+1. `active_o` is 1 for indices from P+T to P+T+A-1, where T is the trim. The porch P and active count A per mode are: 000 124/768, 001 120/640, 010 122/720, 100 164/948, 101 152/768, 110 132/720, 111 120/640. `blank_o` is always the inverse of `active_o`.
- R3: `hb_trim_i` is sign-magnitude. Bit 4 is the sign (1 = earlier) and bits 3:0 are the magnitude in clocks. 10000 means no shift.
- R4: Only the leading edge of H matters. The width of the H pulse has no effect on the window or on the length measurement.
- R5: `line_o` is 1 after reset. It advances by one at each H leading edge and goes from the last line (525 for modes 0xx, 625 for modes 1xx) back to 1.
- R6: For modes 0xx with vertical select 10, video is blanked on lines 1–20, 263–283 and 525.
- R7: For modes 1xx with vertical select 10, video is blanked on lines 1–23, 310–335 and 623–625.
- R8: Vertical select s extends the end of the two top-of-field blanking ranges by 2−s lines (s = 00 adds 2, 01 adds 1, 10 adds 0). Code 11 acts as 10.
- R9: With the field pin not selected, a V leading edge that arrives while H is asserted marks the field odd (`odd_o` = 1) and restarts the line count at 1 on that H edge. A V leading edge while H is deasserted marks the field even and leaves the line count alone.
- R10: With `field_ext_i` = 1, `odd_o` follows the field pin two clocks later, after polarity (pin high = odd when `field_inv_i` = 0).
- R11: `h_inv_i`, `v_inv_i` and `field_inv_i` make the matching pin active low.
- R12: Mode 011 is illegal. It holds the counters cleared: `line_o` = 1, `free_run_o` = 0, and `blank_o` = 1 throughout.
- R13: Directly after reset: `blank_o` = 1, `active_o` = 0, `line_o` = 1, `free_run_o` = 0, `odd_o` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| h_i | input | 1 | Horizontal sync pin |
| v_i | input | 1 | Vertical sync pin |
| field_i | input | 1 | Field indicator pin |
| h_inv_i | input | 1 | H pin is active low |
| v_inv_i | input | 1 | V pin is active low |
| field_inv_i | input | 1 | Field pin is active low (high = even) |
| field_ext_i | input | 1 | Take parity from the field pin |
| mode_i | input | 3 | Line standard code |
| hb_trim_i | input | 5 | Sign-magnitude horizontal blank shift |
| vb_sel_i | input | 2 | Top-of-field blank extension select |
| active_o | output | 1 | Active-video window |
| blank_o | output | 1 | Composite blank |
| odd_o | output | 1 | Field is odd |
| line_o | output | 10 | Current line number, starting at 1 |
| free_run_o | output | 1 | Line length mismatch, subcarrier free-run |

## Verification
The hardest conditions to reach are the blanking boundaries deep in a field and at the frame wrap, such as lines 283, 525 or 623. Running full-length lines to get there would take hundreds of thousands of clocks. Only the H leading edge advances the line count, so the stimulus sends short 16-clock H periods to walk the counter to the line just before the target. It then sends one full-length line and probes the window pixel. The short lines also set the free-run flag on purpose, so every later full-length line checks that the flag clears.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

  localparam int GEOM_W = 11;

  typedef enum logic [2:0] {
    MODE_N_4FSC = 3'b000,
    MODE_N_SQ   = 3'b001,
    MODE_N_601  = 3'b010,
    MODE_BAD    = 3'b011,
    MODE_P_4FSC = 3'b100,
    MODE_P_SQHI = 3'b101,
    MODE_P_601  = 3'b110,
    MODE_P_SQLO = 3'b111
  } vmode_e;

  // porch counts from the H leading edge; porch+act+front is the line length
  typedef struct packed {
    logic [GEOM_W-1:0] porch;
    logic [GEOM_W-1:0] act;
    logic [GEOM_W-1:0] front;
  } hgeom_t;

  function automatic hgeom_t mode_geom(input logic [2:0] m);
    hgeom_t g;
    case (m)
      MODE_N_4FSC: g = '{porch: GEOM_W'(124), act: GEOM_W'(768), front: GEOM_W'(18)};
      MODE_N_SQ:   g = '{porch: GEOM_W'(120), act: GEOM_W'(640), front: GEOM_W'(20)};
      MODE_N_601:  g = '{porch: GEOM_W'(122), act: GEOM_W'(720), front: GEOM_W'(16)};
      MODE_P_4FSC: g = '{porch: GEOM_W'(164), act: GEOM_W'(948), front: GEOM_W'(23)};
      MODE_P_SQHI: g = '{porch: GEOM_W'(152), act: GEOM_W'(768), front: GEOM_W'(24)};
      MODE_P_601:  g = '{porch: GEOM_W'(132), act: GEOM_W'(720), front: GEOM_W'(12)};
      MODE_P_SQLO: g = '{porch: GEOM_W'(120), act: GEOM_W'(640), front: GEOM_W'(20)};
      default:     g = '0;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/vtg_sync_in.sv
module vtg_sync_in #(
  parameter int NCH = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic h_i,
  input  logic v_i,
  input  logic field_i,
  input  logic h_inv_i,
  input  logic v_inv_i,
  input  logic field_inv_i,
  output logic h_lvl_o,
  output logic h_edge_o,
  output logic v_edge_o,
  output logic fld_lvl_o
);

  logic [NCH-1:0] pin_w, inv_w, smp_q;
  logic h_d_q, v_d_q;

  assign pin_w = NCH'({field_i, v_i, h_i});
  assign inv_w = NCH'({field_inv_i, v_inv_i, h_inv_i});

  for (genvar i = 0; i < NCH; i++) begin : g_smp
    always_ff @(posedge clk_i) begin
      if (!rst_ni) smp_q[i] <= 1'b0;
      else         smp_q[i] <= pin_w[i] ^ inv_w[i];
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      h_d_q <= 1'b0;
      v_d_q <= 1'b0;
    end else begin
      h_d_q <= smp_q[0];
      v_d_q <= smp_q[1];
    end
  end

  assign h_lvl_o   = smp_q[0];
  assign h_edge_o  = smp_q[0] & ~h_d_q;
  assign v_edge_o  = smp_q[1] & ~v_d_q;
  assign fld_lvl_o = smp_q[2];

endmodule

// File: rtl/vtg_hcount.sv
module vtg_hcount
  import vtg_pkg::*;
#(
  parameter int PIX_W  = 11,
  parameter int TRIM_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              h_edge_i,
  input  logic [2:0]        mode_i,
  input  logic [TRIM_W-1:0] trim_i,
  output logic              hact_o,
  output logic              free_run_o
);

  localparam int CW = PIX_W + 1;
  localparam logic [PIX_W-1:0] PIX_MAX = '1;

  hgeom_t            geo;
  logic [PIX_W-1:0]  pix_q;
  logic              seen_q, fr_q;
  logic              neg;
  logic [TRIM_W-2:0] mag;
  logic [CW-1:0]     start_w, stop_w, len_w, meas_w;

  assign geo = mode_geom(mode_i);
  assign neg = trim_i[TRIM_W-1];
  assign mag = trim_i[TRIM_W-2:0];

  always_comb begin
    len_w   = CW'(geo.porch) + CW'(geo.act) + CW'(geo.front);
    start_w = neg ? (CW'(geo.porch) - CW'(mag)) : (CW'(geo.porch) + CW'(mag));
    stop_w  = start_w + CW'(geo.act);
    meas_w  = CW'(pix_q) + CW'(1);
  end

  assign hact_o     = (CW'(pix_q) >= start_w) && (CW'(pix_q) < stop_w);
  assign free_run_o = fr_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      pix_q  <= '0;
      seen_q <= 1'b0;
      fr_q   <= 1'b0;
    end else if (clr_i) begin
      pix_q  <= '0;
      seen_q <= 1'b0;
      fr_q   <= 1'b0;
    end else if (h_edge_i) begin
      pix_q  <= '0;
      seen_q <= 1'b1;
      if (seen_q) fr_q <= (meas_w != len_w);
    end else if (pix_q != PIX_MAX) begin
      pix_q <= pix_q + 1'b1;
    end
  end

  // R1
  fr_match_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_edge_i && seen_q && !clr_i && meas_w == len_w) |=> !free_run_o);

  // R1
  fr_mismatch_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_edge_i && seen_q && !clr_i && meas_w != len_w) |=> free_run_o);

  // R2
  act_after_porch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hact_o |-> (CW'(pix_q) + CW'(15) >= CW'(geo.porch)));

endmodule

// File: rtl/vtg_vcount.sv
module vtg_vcount #(
  parameter int LINE_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              h_edge_i,
  input  logic              h_lvl_i,
  input  logic              v_edge_i,
  input  logic              fld_lvl_i,
  input  logic              fld_ext_i,
  input  logic              pal_i,
  input  logic [1:0]        vsel_i,
  output logic [LINE_W-1:0] line_o,
  output logic              odd_o,
  output logic              vblank_o
);

  localparam logic [LINE_W-1:0] ONE      = LINE_W'(1);
  localparam logic [LINE_W-1:0] N_TOTAL  = LINE_W'(525);
  localparam logic [LINE_W-1:0] N_TOP    = LINE_W'(20);
  localparam logic [LINE_W-1:0] N_F2_BEG = LINE_W'(263);
  localparam logic [LINE_W-1:0] N_F2_END = LINE_W'(283);
  localparam logic [LINE_W-1:0] P_TOTAL  = LINE_W'(625);
  localparam logic [LINE_W-1:0] P_TOP    = LINE_W'(23);
  localparam logic [LINE_W-1:0] P_F2_BEG = LINE_W'(310);
  localparam logic [LINE_W-1:0] P_F2_END = LINE_W'(335);
  localparam logic [LINE_W-1:0] P_BOT    = LINE_W'(623);

  logic [LINE_W-1:0] line_q, total, extra;
  logic              armed_q, odd_q, start_now;

  assign total     = pal_i ? P_TOTAL : N_TOTAL;
  assign start_now = v_edge_i & h_lvl_i;

  always_comb begin
    case (vsel_i)
      2'b00:   extra = LINE_W'(2);
      2'b01:   extra = LINE_W'(1);
      default: extra = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni || clr_i) begin
      line_q  <= ONE;
      armed_q <= 1'b0;
      odd_q   <= 1'b1;
    end else begin
      if (h_edge_i) begin
        armed_q <= 1'b0;
        if (start_now || armed_q) line_q <= ONE;
        else if (line_q == total) line_q <= ONE;
        else                      line_q <= line_q + 1'b1;
      end else if (start_now) begin
        armed_q <= 1'b1;
      end
      if (fld_ext_i)     odd_q <= fld_lvl_i;
      else if (v_edge_i) odd_q <= h_lvl_i;
    end
  end

  always_comb begin
    if (pal_i)
      vblank_o = (line_q <= P_TOP + extra) ||
                 (line_q >= P_F2_BEG && line_q <= P_F2_END + extra) ||
                 (line_q >= P_BOT);
    else
      vblank_o = (line_q <= N_TOP + extra) ||
                 (line_q >= N_F2_BEG && line_q <= N_F2_END + extra) ||
                 (line_q == N_TOTAL);
  end

  assign line_o = line_q;
  assign odd_o  = odd_q;

  // R5
  line_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_edge_i && !clr_i && !start_now && !armed_q && line_q != total)
      |=> (clr_i || line_q == $past(line_q) + 1'b1));

  // R9
  odd_coincide_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_edge_i && h_lvl_i && !fld_ext_i && !clr_i) |=> (clr_i || odd_o));

endmodule

// File: rtl/vtg_line_timing.sv
module vtg_line_timing
  import vtg_pkg::*;
#(
  parameter int PIX_W  = 11,
  parameter int LINE_W = 10,
  parameter int TRIM_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              h_i,
  input  logic              v_i,
  input  logic              field_i,
  input  logic              h_inv_i,
  input  logic              v_inv_i,
  input  logic              field_inv_i,
  input  logic              field_ext_i,
  input  logic [2:0]        mode_i,
  input  logic [TRIM_W-1:0] hb_trim_i,
  input  logic [1:0]        vb_sel_i,
  output logic              active_o,
  output logic              blank_o,
  output logic              odd_o,
  output logic [LINE_W-1:0] line_o,
  output logic              free_run_o
);

  logic illegal, h_lvl, h_edge, v_edge, fld_lvl, hact, vblank;

  assign illegal = (mode_i == MODE_BAD);

  vtg_sync_in #(.NCH(3)) u_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .h_i         (h_i),
    .v_i         (v_i),
    .field_i     (field_i),
    .h_inv_i     (h_inv_i),
    .v_inv_i     (v_inv_i),
    .field_inv_i (field_inv_i),
    .h_lvl_o     (h_lvl),
    .h_edge_o    (h_edge),
    .v_edge_o    (v_edge),
    .fld_lvl_o   (fld_lvl)
  );

  vtg_hcount #(.PIX_W(PIX_W), .TRIM_W(TRIM_W)) u_hcnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (illegal),
    .h_edge_i   (h_edge),
    .mode_i     (mode_i),
    .trim_i     (hb_trim_i),
    .hact_o     (hact),
    .free_run_o (free_run_o)
  );

  vtg_vcount #(.LINE_W(LINE_W)) u_vcnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (illegal),
    .h_edge_i  (h_edge),
    .h_lvl_i   (h_lvl),
    .v_edge_i  (v_edge),
    .fld_lvl_i (fld_lvl),
    .fld_ext_i (field_ext_i),
    .pal_i     (mode_i[2]),
    .vsel_i    (vb_sel_i),
    .line_o    (line_o),
    .odd_o     (odd_o),
    .vblank_o  (vblank)
  );

  assign active_o = hact & ~vblank & ~illegal;
  assign blank_o  = ~active_o;

  // R12
  bad_mode_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_BAD) |=> (blank_o && !active_o && !free_run_o));

  // R5
  line_bounds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_o != '0) && (line_o <= (mode_i[2] ? LINE_W'(625) : LINE_W'(525))));

endmodule

// File: tb/vtg_line_timing_tb_top.sv
module vtg_line_timing_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       h_i = 1'b0, v_i = 1'b0, field_i = 1'b0;
  logic       h_inv = 1'b0, v_inv = 1'b0, f_inv = 1'b0, f_ext = 1'b0;
  logic [2:0] mode = 3'b001;
  logic [4:0] trim = 5'b0;
  logic [1:0] vsel = 2'b10;
  logic       active_o, blank_o, odd_o, free_run_o;
  logic [9:0] line_o;

  int n_chk = 0, n_bad = 0, exp_line = 1, cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vtg_line_timing dut_i (
    .clk_i(clk), .rst_ni(rst_n), .h_i(h_i), .v_i(v_i), .field_i(field_i),
    .h_inv_i(h_inv), .v_inv_i(v_inv), .field_inv_i(f_inv), .field_ext_i(f_ext),
    .mode_i(mode), .hb_trim_i(trim), .vb_sel_i(vsel),
    .active_o(active_o), .blank_o(blank_o), .odd_o(odd_o), .line_o(line_o),
    .free_run_o(free_run_o)
  );

  typedef struct packed {
    logic [2:0] mode;
    logic [4:0] trim;
    int         period;
    int         start;
    int         act;
    int         fr;
  } vec_t;

  // R1 R2 R3: mode, trim, H period, expected window start, active count, flag
  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{3'b000, 5'b00000,  910, 124, 768, 0},
    '{3'b001, 5'b00011,  780, 123, 640, 0},
    '{3'b010, 5'b10010,  858, 120, 720, 0},
    '{3'b100, 5'b00000, 1135, 164, 948, 0},
    '{3'b101, 5'b01111,  944, 167, 768, 0},
    '{3'b110, 5'b11111,  864, 117, 720, 0},
    '{3'b111, 5'b10000,  780, 120, 640, 0},
    '{3'b010, 5'b00000,  857, 122, 720, 1},
    '{3'b100, 5'b00000, 1136, 164, 948, 1}
  };

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      n_bad++;
      $display("FAIL watchdog (all requirements): cycles=%0d expected below 190000", cyc);
      finish_run();
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int total_lines(input logic [2:0] m);
    return m[2] ? 625 : 525;
  endfunction

  task automatic do_reset(input logic [2:0] m, input logic [4:0] t, input logic [1:0] s);
    @(negedge clk);
    rst_n = 1'b0; mode = m; trim = t; vsel = s;
    h_i = h_inv; v_i = v_inv; field_i = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    exp_line = 1;
  endtask

  // one H period starting with a leading edge; at negedge j pixel index is j-2
  task automatic run_line(input int period, input int width, input int ppix, input int pexp,
                          input int efr, input bit lchk, input string tag);
    exp_line = (exp_line == total_lines(mode)) ? 1 : exp_line + 1;
    for (int j = 0; j < period; j++) begin
      @(negedge clk);
      if (j == 2 && lchk) chk({tag, " line"}, int'(line_o), exp_line);
      if (j == 2 && efr >= 0) chk({tag, " free-run"}, int'(free_run_o), efr);
      if (ppix >= 0 && j - 2 == ppix) begin
        chk({tag, " active"}, int'(active_o), pexp);
        chk({tag, " blank"}, int'(blank_o), int'(pexp == 0));
      end
      h_i = (j < width) ^ h_inv;
    end
  endtask

  task automatic probe_line(input int n, input int len, input int pix, input int e, input string tag);
    while (exp_line != n - 1) run_line(16, 1, -1, 0, -1, 1'b0, "");
    run_line(len, 1, pix, e, -1, 1'b1, tag);
  endtask

  initial begin
    // R13 reset state
    do_reset(3'b001, 5'b0, 2'b10);
    @(negedge clk);
    chk("R13 blank", int'(blank_o), 1);
    chk("R13 active", int'(active_o), 0);
    chk("R13 line", int'(line_o), 1);
    chk("R13 free-run", int'(free_run_o), 0);
    chk("R13 odd", int'(odd_o), 1);

    // table walk: R1 R2 R3
    for (int i = 0; i < NV; i++) begin
      do_reset(VECS[i].mode, VECS[i].trim, 2'b10);
      repeat (24) run_line(16, 1, -1, 0, -1, 1'b0, "");
      run_line(VECS[i].period, 1, VECS[i].start - 1, 0, 1, 1'b1,
               $sformatf("R1 R2 R3 vec%0d before start", i));
      run_line(VECS[i].period, 1, VECS[i].start, 1, -1, 1'b0,
               $sformatf("R2 R3 vec%0d start", i));
      run_line(VECS[i].period, 1, VECS[i].start + VECS[i].act - 1, 1, -1, 1'b0,
               $sformatf("R2 R3 vec%0d last", i));
      run_line(VECS[i].period, 1, VECS[i].start + VECS[i].act, 0, -1, 1'b0,
               $sformatf("R2 R3 vec%0d after end", i));
      run_line(16, 1, -1, 0, VECS[i].fr, 1'b0, $sformatf("R1 vec%0d flag", i));
    end

    // R4 wide H pulses
    do_reset(3'b001, 5'b0, 2'b10);
    repeat (24) run_line(16, 1, -1, 0, -1, 1'b0, "");
    run_line(780, 600, 120, 1, 1, 1'b1, "R4 wide pulse start");
    run_line(780, 700, 119, 0, 0, 1'b1, "R4 wide pulse porch");
    run_line(16, 1, -1, 0, 0, 1'b0, "R4 wide pulse length");

    // R5 R6 NTSC vertical blanking, select 10
    do_reset(3'b001, 5'b0, 2'b10);
    probe_line(20, 780, 130, 0, "R6 line 20");
    probe_line(21, 780, 130, 1, "R6 line 21");
    probe_line(262, 780, 130, 1, "R6 line 262");
    probe_line(263, 780, 130, 0, "R6 line 263");
    probe_line(283, 780, 130, 0, "R6 line 283");
    probe_line(284, 780, 130, 1, "R6 line 284");
    probe_line(524, 780, 130, 1, "R6 line 524");
    probe_line(525, 780, 130, 0, "R6 line 525");
    run_line(16, 1, -1, 0, -1, 1'b1, "R5 wrap 525");

    // R8 vertical select
    do_reset(3'b001, 5'b0, 2'b00);
    probe_line(22, 780, 130, 0, "R8 sel00 line 22");
    probe_line(23, 780, 130, 1, "R8 sel00 line 23");
    probe_line(285, 780, 130, 0, "R8 sel00 line 285");
    probe_line(286, 780, 130, 1, "R8 sel00 line 286");
    do_reset(3'b001, 5'b0, 2'b01);
    probe_line(21, 780, 130, 0, "R8 sel01 line 21");
    probe_line(22, 780, 130, 1, "R8 sel01 line 22");
    do_reset(3'b001, 5'b0, 2'b11);
    probe_line(20, 780, 130, 0, "R8 sel11 line 20");
    probe_line(21, 780, 130, 1, "R8 sel11 line 21");

    // R7 PAL vertical blanking
    do_reset(3'b111, 5'b0, 2'b10);
    probe_line(23, 780, 130, 0, "R7 line 23");
    probe_line(24, 780, 130, 1, "R7 line 24");
    probe_line(309, 780, 130, 1, "R7 line 309");
    probe_line(310, 780, 130, 0, "R7 line 310");
    probe_line(335, 780, 130, 0, "R7 line 335");
    probe_line(336, 780, 130, 1, "R7 line 336");
    probe_line(622, 780, 130, 1, "R7 line 622");
    probe_line(623, 780, 130, 0, "R7 line 623");
    probe_line(625, 780, 130, 0, "R7 line 625");
    run_line(16, 1, -1, 0, -1, 1'b1, "R5 wrap 625");

    // R9 field parity from coincidence
    do_reset(3'b001, 5'b0, 2'b10);
    repeat (4) run_line(16, 1, -1, 0, -1, 1'b1, "R5 count");
    @(negedge clk); h_i = 1'b1; v_i = 1'b1;
    @(negedge clk); h_i = 1'b0;
    @(negedge clk);
    chk("R9 odd start line", int'(line_o), 1);
    chk("R9 odd flag", int'(odd_o), 1);
    exp_line = 1;
    repeat (2) run_line(16, 1, -1, 0, -1, 1'b1, "R9 held V");
    v_i = 1'b0;
    run_line(16, 1, -1, 0, -1, 1'b1, "R9 V low");
    @(negedge clk); v_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 even flag", int'(odd_o), 0);
    chk("R9 even keeps line", int'(line_o), exp_line);
    v_i = 1'b0;

    // R11 inverted H and V
    h_inv = 1'b1; v_inv = 1'b1;
    do_reset(3'b001, 5'b0, 2'b10);
    repeat (3) run_line(16, 1, -1, 0, -1, 1'b1, "R11 inverted H count");
    @(negedge clk); h_i = 1'b0; v_i = 1'b0;
    @(negedge clk); h_i = 1'b1;
    @(negedge clk);
    chk("R11 inverted odd line", int'(line_o), 1);
    chk("R11 inverted odd flag", int'(odd_o), 1);
    exp_line = 1;
    probe_line(30, 780, 120, 1, "R11 inverted window");
    v_i = 1'b1;
    h_inv = 1'b0; v_inv = 1'b0;

    // R10 field pin
    f_ext = 1'b1; f_inv = 1'b1;
    do_reset(3'b001, 5'b0, 2'b10);
    @(negedge clk); field_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 R11 inverted field high", int'(odd_o), 0);
    field_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 R11 inverted field low", int'(odd_o), 1);
    f_inv = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 plain field low", int'(odd_o), 0);
    field_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 plain field high", int'(odd_o), 1);
    f_ext = 1'b0; field_i = 1'b0;

    // R12 illegal mode
    do_reset(3'b011, 5'b0, 2'b10);
    @(negedge clk);
    chk("R12 blank", int'(blank_o), 1);
    repeat (30) run_line(16, 1, -1, 0, -1, 1'b0, "");
    run_line(780, 1, 130, 0, -1, 1'b0, "R12 window");
    run_line(780, 1, 300, 0, -1, 1'b0, "R12 window");
    chk("R12 line held", int'(line_o), 1);
    chk("R12 free-run clear", int'(free_run_o), 0);

    finish_run();
  end

endmodule